// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block chooses, each clock, which of eight frame DMA channels may move one beat between memory and one of the two CPU ports of a switch core. Channels 0 to 5 carry frames into the switch, and each of them has a configuration bit that routes it to CPU port 0 or CPU port 1. Channel 6 takes frames out through CPU port 0 and channel 7 takes frames out through CPU port 1.

Within a port, an extraction request always wins over injection. Among injection channels, the highest channel number wins. Once an injection channel has been granted a beat that does not end its frame, it owns the injection side of its port until its end-of-frame beat is granted. Between the two ports, a round-robin pointer shares the beats evenly when both ports have demand. A port with no demand never holds back the other port.

The result is a registered one-hot grant, a valid flag and the served port. The grant is due one clock after the request that caused it.

Top module: `dma_chan_arb`

## Requirements
- R1: `gnt_o` is zero or one-hot. It is registered, so it shows the decision made from the inputs of the previous clock. `gnt_vld_o` is high exactly when `gnt_o` is nonzero. `gnt_port_o` gives the CPU port served (0 or 1).
- R2: Channels 0 to 5 are injection channels. Bit c of `inj_port_i` sends channel c to CPU port 0 when it is 0 and to port 1 when it is 1. Channel 6 always serves port 0 and channel 7 always serves port 1.
- R3: When the extraction channel of a port requests, that port's candidate is the extraction channel, and any injection request on the same port waits.
- R4: When no injection channel owns a port, the requesting injection channel with the highest number among those routed to that port is chosen.
- R5: When both ports have a candidate, the port named by the round-robin pointer is served and the pointer then flips. Consecutive beats therefore alternate between the ports, starting with port 0 after reset.
- R6: When only one port has a candidate, that port is served in every such cycle and the pointer does not change.
- R7: A granted injection beat with its `eof_i` bit low makes that channel the owner of its port. No other injection channel is granted on that port until the owner's beat with `eof_i` high has been granted, even in cycles when the owner's request is low.
- R8: Extraction beats granted on a port do not end or move the injection ownership of that port.
- R9: Reset clears the grant, clears the ownership of both ports and sets the pointer to port 0.
- R10: A channel is never granted unless its `req_i` bit was high in the cycle the decision was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Per-channel beat request |
| eof_i | input | 8 | Per-channel marker that the requested beat ends a frame |
| inj_port_i | input | 6 | Per-injection-channel CPU port select |
| gnt_o | output | 8 | One-hot registered grant |
| gnt_vld_o | output | 1 | A grant is present |
| gnt_port_o | output | 1 | CPU port of the present grant |

## Verification
Every decision passes through one register, so a grant is due exactly one clock after the inputs that produced it. The bench drives requests, end-of-frame markers and the port selects on the falling edge. It reads `gnt_o`, `gnt_vld_o` and `gnt_port_o` on the next falling edge, after the single rising edge that registers them and before it changes the inputs again. State effects such as ownership and the pointer are not visible directly. They are checked on the following beats, whose expected grants depend on them. For those checks each step compares only the one decision that step produced.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NUM_INJ  = 6;
  localparam int NUM_PORT = 2;
  localparam int NUM_CH   = NUM_INJ + NUM_PORT;
  localparam int CH_W     = $clog2(NUM_CH);

  typedef logic [CH_W-1:0] ch_idx_t;

  typedef struct packed {
    logic    vld;
    ch_idx_t ch;
  } owner_t;
endpackage

// File: rtl/dma_arb_port_pick.sv
module dma_arb_port_pick
  import dma_arb_pkg::*;
#(
  parameter int PORT_ID = 0
) (
  input  logic [NUM_CH-1:0]  req_i,
  input  logic [NUM_INJ-1:0] inj_port_i,
  input  owner_t             owner_i,
  output logic               want_o,
  output ch_idx_t            ch_o,
  output logic               inj_o
);
  localparam int EXT_CH = NUM_INJ + PORT_ID;

  logic    ext_req;
  logic    free_found;
  ch_idx_t free_ch;
  logic    inj_ok;
  ch_idx_t inj_ch;

  assign ext_req = req_i[EXT_CH];

  // ascending scan, last hit wins: highest channel number
  always_comb begin
    free_found = 1'b0;
    free_ch    = '0;
    for (int c = 0; c < NUM_INJ; c++) begin
      if (req_i[c] && (inj_port_i[c] == 1'(PORT_ID))) begin
        free_found = 1'b1;
        free_ch    = ch_idx_t'(c);
      end
    end
  end

  always_comb begin
    if (owner_i.vld) begin
      inj_ok = req_i[owner_i.ch];
      inj_ch = owner_i.ch;
    end else begin
      inj_ok = free_found;
      inj_ch = free_ch;
    end
  end

  assign want_o = ext_req | inj_ok;
  assign ch_o   = ext_req ? ch_idx_t'(EXT_CH) : inj_ch;
  assign inj_o  = ~ext_req;
endmodule

// File: rtl/dma_arb_owner.sv
module dma_arb_owner
  import dma_arb_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    take_i,
  input  ch_idx_t ch_i,
  input  logic    eof_i,
  output owner_t  owner_o
);
  owner_t own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     own_q <= '0;
    else if (take_i) own_q <= eof_i ? '0 : '{vld: 1'b1, ch: ch_i};
  end

  assign owner_o = own_q;

  // R2
  owner_is_inj_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_q.vld |-> (int'(own_q.ch) < NUM_INJ));
endmodule

// File: rtl/dma_chan_arb.sv
module dma_chan_arb
  import dma_arb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CH-1:0]  req_i,
  input  logic [NUM_CH-1:0]  eof_i,
  input  logic [NUM_INJ-1:0] inj_port_i,
  output logic [NUM_CH-1:0]  gnt_o,
  output logic               gnt_vld_o,
  output logic               gnt_port_o
);
  logic [NUM_PORT-1:0] want;
  logic [NUM_PORT-1:0] pick_inj;
  logic [NUM_PORT-1:0] take;
  ch_idx_t             pick_ch [NUM_PORT];
  owner_t              own     [NUM_PORT];

  logic                both, any, sel, rr_q;
  logic [NUM_CH-1:0]   gnt_d, gnt_q;
  logic                port_q;

  for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
    dma_arb_port_pick #(.PORT_ID(p)) u_pick (
      .req_i      (req_i),
      .inj_port_i (inj_port_i),
      .owner_i    (own[p]),
      .want_o     (want[p]),
      .ch_o       (pick_ch[p]),
      .inj_o      (pick_inj[p])
    );

    dma_arb_owner u_own (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .take_i  (take[p]),
      .ch_i    (pick_ch[p]),
      .eof_i   (eof_i[pick_ch[p]]),
      .owner_o (own[p])
    );
  end

  always_comb begin
    both  = &want;
    any   = |want;
    sel   = both ? rr_q : want[1];
    gnt_d = '0;
    if (any) gnt_d[pick_ch[sel]] = 1'b1;
    for (int p = 0; p < NUM_PORT; p++)
      take[p] = any && (sel == 1'(p)) && pick_inj[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q  <= '0;
      port_q <= 1'b0;
      rr_q   <= 1'b0;
    end else begin
      gnt_q  <= gnt_d;
      port_q <= sel;
      if (both) rr_q <= ~rr_q;
    end
  end

  assign gnt_o      = gnt_q;
  assign gnt_vld_o  = |gnt_q;
  assign gnt_port_o = port_q;

  // R1
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R10
  gnt_had_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |-> ((gnt_o & ~$past(req_i)) == '0));

  // R5
  rr_alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (want == 2'b11) |=> (gnt_port_o == $past(rr_q)) && (rr_q != $past(rr_q)));

  for (genvar p = 0; p < NUM_PORT; p++) begin : g_chk
    // R3
    ext_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_vld_o && (gnt_port_o == 1'(p)) && $past(req_i[NUM_INJ+p]))
        |-> gnt_o[NUM_INJ+p]);

    // R7
    owner_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (own[p].vld && take[p]) |=> (gnt_o == (NUM_CH'(1) << $past(own[p].ch))));
  end
endmodule

// File: tb/sim_dma_chan_arb.sv
`timescale 1ns/1ps
module sim_dma_chan_arb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic [7:0] eof = '0;
  logic [5:0] cfg = '0;
  logic [7:0] gnt;
  logic       gnt_vld;
  logic       gnt_port;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dma_chan_arb u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_i      (req),
    .eof_i      (eof),
    .inj_port_i (cfg),
    .gnt_o      (gnt),
    .gnt_vld_o  (gnt_vld),
    .gnt_port_o (gnt_port)
  );

  task automatic do_reset(input logic [5:0] c);
    @(negedge clk);
    req = '0; eof = '0; cfg = c;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive at a falling edge, sample at the next one (one register)
  task automatic step(input logic [7:0] r, input logic [7:0] e,
                      input logic [7:0] exp_g, input logic exp_p, input string tag);
    req = r; eof = e;
    @(negedge clk);
    n_vec++;
    if (gnt !== exp_g || gnt_vld !== (|exp_g) || ((|exp_g) && gnt_port !== exp_p)) begin
      n_bad++;
      $display("FAIL %s: gnt=%h vld=%b port=%b expected gnt=%h vld=%b port=%b",
               tag, gnt, gnt_vld, gnt_port, exp_g, |exp_g, exp_p);
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    req = 8'hFF; eof = '0;
    @(negedge clk); @(negedge clk);
    n_vec++;
    if (gnt !== 8'h00 || gnt_vld !== 1'b0 || gnt_port !== 1'b0) begin
      n_bad++;
      $display("FAIL R9: gnt=%h vld=%b port=%b expected gnt=00 vld=0 port=0",
               gnt, gnt_vld, gnt_port);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_inj_route();
    do_reset(6'h01);
    step(8'h05, 8'h05, 8'h04, 1'b0, "R2 ch2 on port0");
    step(8'h05, 8'h05, 8'h01, 1'b1, "R2 ch0 routed to port1");
    step(8'h00, 8'h00, 8'h00, 1'b0, "R10 idle");
  endtask

  task automatic t_ext_first();
    do_reset(6'h20);
    step(8'hA0, 8'hA0, 8'h80, 1'b1, "R3 ch7 over ch5");
    step(8'h20, 8'h20, 8'h20, 1'b1, "R3 ch5 after ch7");
  endtask

  task automatic t_high_first();
    do_reset(6'h00);
    step(8'h12, 8'h12, 8'h10, 1'b0, "R4 ch4 over ch1");
    step(8'h02, 8'h02, 8'h02, 1'b0, "R4 ch1 next");
  endtask

  task automatic t_owner();
    do_reset(6'h00);
    step(8'h02, 8'h00, 8'h02, 1'b0, "R7 ch1 starts frame");
    step(8'h0A, 8'h00, 8'h02, 1'b0, "R7 owner over ch3");
    step(8'h08, 8'h00, 8'h00, 1'b0, "R7 ch3 blocked while owner idle");
    step(8'h0A, 8'h02, 8'h02, 1'b0, "R7 owner eof beat");
    step(8'h08, 8'h08, 8'h08, 1'b0, "R7 ch3 after release");
  endtask

  task automatic t_ext_keeps_owner();
    do_reset(6'h00);
    step(8'h02, 8'h00, 8'h02, 1'b0, "R8 ch1 starts frame");
    step(8'h4A, 8'h00, 8'h40, 1'b0, "R8 ch6 interleaves");
    step(8'h0A, 8'h00, 8'h02, 1'b0, "R8 ch1 still owns");
    step(8'h0A, 8'h02, 8'h02, 1'b0, "R8 ch1 eof");
  endtask

  task automatic t_rr();
    do_reset(6'h00);
    step(8'hC0, 8'hC0, 8'h40, 1'b0, "R5 beat0 port0");
    step(8'hC0, 8'hC0, 8'h80, 1'b1, "R5 beat1 port1");
    step(8'hC0, 8'hC0, 8'h40, 1'b0, "R5 beat2 port0");
    step(8'hC0, 8'hC0, 8'h80, 1'b1, "R5 beat3 port1");
  endtask

  task automatic t_no_block();
    do_reset(6'h20);
    step(8'h02, 8'h00, 8'h02, 1'b0, "R6 ch1 owns port0");
    step(8'h20, 8'h20, 8'h20, 1'b1, "R6 port1 free while owner idle");
    for (int i = 0; i < 3; i++)
      step(8'h80, 8'h80, 8'h80, 1'b1, "R6 lone port1");
    step(8'hC0, 8'hC0, 8'h40, 1'b0, "R6 pointer unmoved");
    step(8'hC0, 8'hC0, 8'h80, 1'b1, "R5 then port1");
  endtask

  task automatic t_reset_clears();
    do_reset(6'h00);
    step(8'h02, 8'h00, 8'h02, 1'b0, "R9 ch1 owns");
    step(8'hC0, 8'hC0, 8'h40, 1'b0, "R9 pointer moves");
    do_reset(6'h00);
    step(8'h08, 8'h08, 8'h08, 1'b0, "R9 ownership cleared");
    step(8'hC0, 8'hC0, 8'h40, 1'b0, "R9 pointer at port0");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run still busy, expected end");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_inj_route();
    t_ext_first();
    t_high_first();
    t_owner();
    t_ext_keeps_owner();
    t_rr();
    t_no_block();
    t_reset_clears();
    finish_run();
  end
endmodule